// File: doc/BRIEF.md
# Capture Timer

This block is a 32-bit general-purpose timer with one input-capture channel. It sits on a simple word-indexed register bus. A free-running prescaler produces a count tick. The tick rate is one of eight power-of-two fractions of the system clock. On each tick the main counter increments. When the counter equals a programmable threshold, the next tick returns it to zero and counting continues. Each such wrap raises a sticky match flag.

The external capture pin first passes through a two-stage synchroniser. It can then optionally pass through a glitch filter. Rising edges, falling edges or both can be armed. On an armed edge the current counter value is copied into a read-only capture register, and a sticky capture flag is raised. Software clears either flag by writing 0 to its bit of the control word; writing 1 leaves it set. A single level interrupt request reflects each flag that has its enable bit set.

Top module: `capture_timer`

## Requirements
- R1: After reset all four registers read 0 and `irq` is low.
- R2: Word index 0 is control, 1 is threshold, 2 is counter and 3 is capture. `bus_rdata` shows the register selected by `bus_addr` one clock later. Control bits [8:0] read back as written: bit 0 is enable, bits 3:1 are the prescale code, bit 4 is the match IRQ enable, bit 5 is the capture IRQ enable, bit 6 arms the rising edge, bit 7 arms the falling edge and bit 8 turns on the filter. All other control bits read 0 except the flags.
- R3: With the unit enabled, the counter advances once every D clocks. Prescale codes 0..7 give D = 2, 4, 8, 64, 128, 1024, 2048 and 4096. The prescaler restarts from zero whenever the unit is disabled, so N clocks after enabling the counter has advanced floor(N/D) times.
- R4: A tick that finds the counter equal to the threshold loads zero instead of incrementing. That same tick sets the match flag, which is control bit 30.
- R5: Writing 0 to bit 30 or bit 31 of control clears that flag. Writing 1 leaves the flag unchanged, and no other action clears it except reset.
- R6: When bit 6 or bit 7 is set and the matching edge of the synchronised pin is seen, the counter value is copied to the capture register. The capture flag, bit 31, is then set. An edge whose arm bit is clear is ignored.
- R7: With bit 8 set, a pin level change is accepted only after 4 consecutive equal synchronised samples, so a 2-clock pulse is ignored. With bit 8 clear, a 2-clock pulse is captured.
- R8: While bit 0 is clear, the counter holds its value, no capture happens and no flag is set.
- R9: Bus writes to word index 3 have no effect on the capture register.
- R10: `irq` is (match flag AND bit 4) OR (capture flag AND bit 5), registered one clock.
- R11: A bus write to word index 2 loads the counter directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Word index: 0 control, 1 threshold, 2 counter, 3 capture |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the addressed word |
| cap_pin | input | 1 | Asynchronous capture input |
| irq | output | 1 | Level interrupt request |

## Verification
The prescaler is swept over all eight codes. Each code gets an enabled window one clock short of three periods and another one clock past three periods, which pins each divisor to an exact value rather than a neighbour. The wrap is tried with windows that end on the threshold and one tick past it, which separates "reaches threshold" from "wraps and flags". Capture is exercised with rising-only, falling-only and both-edge arming, each with the opposite edge also applied so that an unarmed edge would show up. Short and long pulses are applied with and without the filter, and the same pin activity is repeated with the unit disabled.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

  // word indices on the register bus
  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_THR  = 2'd1;
  localparam logic [1:0] IDX_CNT  = 2'd2;
  localparam logic [1:0] IDX_CAP  = 2'd3;

  // configuration half of the control word, bit 0 = enable ... bit 8 = filter
  typedef struct packed {
    logic       filt;
    logic       arm_fall;
    logic       arm_rise;
    logic       ie_cap;
    logic       ie_match;
    logic [2:0] psel;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // log2 of the tick divisor for each prescale code
  function automatic int psc_shift(input logic [2:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 3;
      3'd3:    return 6;
      3'd4:    return 7;
      3'd5:    return 10;
      3'd6:    return 11;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/ctm_prescaler.sv
module ctm_prescaler #(
  parameter int PSC_W = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  import ctm_pkg::*;

  logic [PSC_W-1:0] pcnt_q;
  logic [PSC_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst || !run) pcnt_q <= '0;
    else             pcnt_q <= pcnt_q + 1'b1;
  end

  // tick when all low bits of the selected width are ones
  always_comb begin
    mask = '0;
    for (int i = 0; i < PSC_W; i++) begin
      if (i < psc_shift(sel)) mask[i] = 1'b1;
    end
    tick = run && ((pcnt_q & mask) == mask);
  end

endmodule

// File: rtl/ctm_capture_front.sv
module ctm_capture_front #(
  parameter int SYNC_ST  = 2,
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic filt_on,
  output logic rise,
  output logic fall
);

  logic [SYNC_ST-1:0]  sync_q;
  logic [FILT_LEN-2:0] hist_q;
  logic [FILT_LEN-1:0] win;
  logic                smp;
  logic                lvl_q;
  logic                prev_q;
  logic                lvl_d;

  assign smp = sync_q[SYNC_ST-1];
  assign win = {hist_q, smp};

  always_comb begin
    if (!filt_on)      lvl_d = smp;
    else if (&win)     lvl_d = 1'b1;
    else if (~|win)    lvl_d = 1'b0;
    else               lvl_d = lvl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      hist_q <= '0;
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_ST-2:0], pin};
      hist_q <= win[FILT_LEN-2:0];
      lvl_q  <= lvl_d;
      prev_q <= lvl_q;
    end
  end

  assign rise = lvl_q & ~prev_q;
  assign fall = ~lvl_q & prev_q;

endmodule

// File: rtl/capture_timer.sv
module capture_timer #(
  parameter int DATA_W   = 32,
  parameter int PSC_W    = 12,
  parameter int SYNC_ST  = 2,
  parameter int FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cap_pin,
  output logic              irq
);
  import ctm_pkg::*;

  localparam int FM_BIT = DATA_W - 2;
  localparam int FC_BIT = DATA_W - 1;

  ctrl_t             ctrl_q;
  logic              fm_q, fc_q;
  logic [DATA_W-1:0] thr_q, cnt_q, cap_q, rdata_q;
  logic              irq_q;
  logic              tick, rise_ev, fall_ev;
  logic              wr_ctrl, wr_thr, wr_cnt;
  logic              match_hit, cap_hit;
  logic [DATA_W-1:0] rd_ctrl, rd_word;

  assign wr_ctrl = bus_wr && (bus_addr == IDX_CTRL);
  assign wr_thr  = bus_wr && (bus_addr == IDX_THR);
  assign wr_cnt  = bus_wr && (bus_addr == IDX_CNT);

  ctm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk  (clk),
    .rst  (rst),
    .run  (ctrl_q.en),
    .sel  (ctrl_q.psel),
    .tick (tick)
  );

  ctm_capture_front #(.SYNC_ST(SYNC_ST), .FILT_LEN(FILT_LEN)) u_front (
    .clk     (clk),
    .rst     (rst),
    .pin     (cap_pin),
    .filt_on (ctrl_q.filt),
    .rise    (rise_ev),
    .fall    (fall_ev)
  );

  assign match_hit = tick && (cnt_q == thr_q);
  assign cap_hit   = ctrl_q.en && ((rise_ev && ctrl_q.arm_rise) ||
                                   (fall_ev && ctrl_q.arm_fall));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      fm_q   <= 1'b0;
      fc_q   <= 1'b0;
      thr_q  <= '0;
      cnt_q  <= '0;
      cap_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      // new events win over a clearing write in the same cycle
      fm_q <= match_hit | (fm_q & ~(wr_ctrl & ~bus_wdata[FM_BIT]));
      fc_q <= cap_hit   | (fc_q & ~(wr_ctrl & ~bus_wdata[FC_BIT]));
      if (wr_thr) thr_q <= bus_wdata;
      if (wr_cnt)         cnt_q <= bus_wdata;
      else if (match_hit) cnt_q <= '0;
      else if (tick)      cnt_q <= cnt_q + 1'b1;
      if (cap_hit) cap_q <= cnt_q;
      irq_q <= (fm_q & ctrl_q.ie_match) | (fc_q & ctrl_q.ie_cap);
    end
  end

  always_comb begin
    rd_ctrl = '0;
    rd_ctrl[CTRL_W-1:0] = ctrl_q;
    rd_ctrl[FM_BIT] = fm_q;
    rd_ctrl[FC_BIT] = fc_q;
    case (bus_addr)
      IDX_CTRL: rd_word = rd_ctrl;
      IDX_THR:  rd_word = thr_q;
      IDX_CNT:  rd_word = cnt_q;
      default:  rd_word = cap_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_word;
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

endmodule

// File: rtl/ctm_checker.sv
module ctm_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              run,
  input logic              fm,
  input logic              fc,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] cap,
  input logic              irq
);

  // R5
  match_flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fm && !(bus_wr && bus_addr == 2'd0 && !bus_wdata[DATA_W-2])) |=> fm);

  // R5
  cap_flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fc && !(bus_wr && bus_addr == 2'd0 && !bus_wdata[DATA_W-1])) |=> fc);

  // R8
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !(bus_wr && bus_addr == 2'd2)) |=> $stable(cnt));

  // R8
  no_match_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !fm) |=> !fm);

  // R6
  cap_update_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (cap != $past(cap)) |-> fc);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!fm && !fc) |=> !irq);

endmodule

bind capture_timer ctm_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .run       (ctrl_q.en),
  .fm        (fm_q),
  .fc        (fc_q),
  .cnt       (cnt_q),
  .cap       (cap_q),
  .irq       (irq)
);

// File: tb/capture_timer_tb.sv
`timescale 1ns/1ps
module capture_timer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cap_pin = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  capture_timer u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cap_pin   (cap_pin),
    .irq       (irq)
  );

  localparam logic [31:0] EN   = 32'h1;
  localparam logic [31:0] IEM  = 32'h10;
  localparam logic [31:0] IEC  = 32'h20;
  localparam logic [31:0] RISE = 32'h40;
  localparam logic [31:0] FALL = 32'h80;
  localparam logic [31:0] FILT = 32'h100;
  localparam logic [31:0] FM   = 32'h4000_0000;
  localparam logic [31:0] FC   = 32'h8000_0000;
  localparam logic [31:0] SLOW = 32'hE;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cap_setup(input logic [31:0] bits, input logic [31:0] start);
    wr(2'd0, 32'h0);
    wr(2'd0, bits | EN | SLOW);
    wr(2'd2, start);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int divs [8] = '{2, 4, 8, 64, 128, 1024, 2048, 4096};
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check($sformatf("R1 reg %0d", a), v, 32'h0);
    end
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R3 prescaler sweep: windows of 3D-1 and 3D+1 clocks
    for (int c = 0; c < 8; c++) begin
      for (int s = 0; s < 2; s++) begin
        int k = (s == 0) ? 3 * divs[c] - 1 : 3 * divs[c] + 1;
        wr(2'd0, 32'h0);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, 32'h0);
        wr(2'd0, EN | (32'(c) << 1));
        idle(k - 1);
        wr(2'd0, 32'h0);
        rd(2'd2, v);
        check($sformatf("R3 code %0d window %0d", c, k), v, 32'(k / divs[c]));
      end
    end

    // R4 wrap with threshold 5 at divisor 2: 6 ticks -> wrapped
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd5);
    wr(2'd2, 32'h0);
    wr(2'd0, EN | IEM);
    idle(12);
    wr(2'd0, IEM | FM);
    rd(2'd2, v);
    check("R4 wrapped to zero", v, 32'h0);
    rd(2'd0, v);
    check("R4 match flag set", v, IEM | FM);
    idle(2);
    check("R10 irq on match", {31'h0, irq}, 32'h1);
    wr(2'd0, IEM | FM);
    rd(2'd0, v);
    check("R5 write one keeps flag", v, IEM | FM);
    wr(2'd0, IEM);
    rd(2'd0, v);
    check("R5 write zero clears flag", v, IEM);
    idle(2);
    check("R10 irq drops", {31'h0, irq}, 32'h0);

    // R4 five ticks: reaches threshold, no flag yet
    wr(2'd2, 32'h0);
    wr(2'd0, EN);
    idle(10);
    wr(2'd0, 32'h0);
    rd(2'd2, v);
    check("R4 at threshold", v, 32'd5);
    rd(2'd0, v);
    check("R4 no flag before wrap", v, 32'h0);
    idle(50);
    rd(2'd2, v);
    check("R8 counter holds while off", v, 32'd5);

    // R6 rising only
    cap_setup(RISE | IEC, 32'd100);
    cap_pin = 1'b1; idle(12);
    rd(2'd3, v);
    check("R6 rise capture", v, 32'd100);
    rd(2'd0, v);
    check("R6 capture flag", v, FC | RISE | IEC | EN | SLOW);
    check("R10 irq on capture", {31'h0, irq}, 32'h1);
    wr(2'd2, 32'd200);
    cap_pin = 1'b0; idle(12);
    rd(2'd3, v);
    check("R6 fall ignored when unarmed", v, 32'd100);

    // R6 falling only
    cap_setup(FALL, 32'd300);
    cap_pin = 1'b1; idle(12);
    rd(2'd3, v);
    check("R6 rise ignored when unarmed", v, 32'd100);
    cap_pin = 1'b0; idle(12);
    rd(2'd3, v);
    check("R6 fall capture", v, 32'd300);
    check("R10 irq masked", {31'h0, irq}, 32'h0);

    // R6 both edges
    cap_setup(RISE | FALL, 32'd400);
    cap_pin = 1'b1; idle(12);
    rd(2'd3, v);
    check("R6 both rise", v, 32'd400);
    wr(2'd2, 32'd500);
    cap_pin = 1'b0; idle(12);
    rd(2'd3, v);
    check("R6 both fall", v, 32'd500);

    // R7 filter rejects short pulse, accepts long level
    cap_setup(RISE | FILT, 32'd600);
    cap_pin = 1'b1; idle(2); cap_pin = 1'b0; idle(20);
    rd(2'd0, v);
    check("R7 short pulse filtered", v & FC, 32'h0);
    rd(2'd3, v);
    check("R7 capture unchanged", v, 32'd500);
    cap_pin = 1'b1; idle(15);
    rd(2'd3, v);
    check("R7 long level passes", v, 32'd600);

    // R7 unfiltered short pulse accepted
    cap_setup(RISE, 32'd650);
    cap_pin = 1'b0; idle(12);
    cap_pin = 1'b1; idle(2); cap_pin = 1'b0; idle(12);
    rd(2'd3, v);
    check("R7 unfiltered short pulse", v, 32'd650);

    // R8 disabled: no capture, no flag
    wr(2'd0, 32'h0);
    wr(2'd2, 32'd700);
    wr(2'd0, RISE | FALL);
    cap_pin = 1'b1; idle(12); cap_pin = 1'b0; idle(12);
    rd(2'd3, v);
    check("R8 no capture while off", v, 32'd650);
    rd(2'd0, v);
    check("R8 no flag while off", v, RISE | FALL);
    rd(2'd2, v);
    check("R8 counter unchanged", v, 32'd700);

    // R9 capture register is read-only
    wr(2'd3, 32'hDEAD_BEEF);
    rd(2'd3, v);
    check("R9 capture read-only", v, 32'd650);

    // R2 / R11 readback
    wr(2'd0, 32'h0000_01FE);
    rd(2'd0, v);
    check("R2 control fields", v, 32'h0000_01FE);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h1234_5678);
    rd(2'd1, v);
    check("R2 threshold", v, 32'h1234_5678);
    wr(2'd2, 32'hABCD_EF01);
    rd(2'd2, v);
    check("R11 counter write", v, 32'hABCD_EF01);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule